// File: doc/BRIEF.md
# Register Rename Status Table

This block sits at the issue stage of an out-of-order floating-point core. It holds the committed value of each of the sixteen floating-point registers. Next to each value it keeps a status tag that names the reservation station due to produce the next value. Tag zero means no write is pending. When an instruction issues, the block looks up both of its source registers. For each one it returns either a usable value or the tag of the station the consumer must wait on. In the same cycle it records the issuing station's tag as the new pending producer of the destination register.

Results come back on a single result bus as a tag and data pair. A register takes the data only when its recorded tag equals the tag on the bus. Its status then returns to blank. A register that a younger instruction has already renamed holds the younger tag, so it lets an older result go past. This removes write-after-write and write-after-read hazards without stalling issue. A lookup made in the same cycle as a matching broadcast gets the bus data directly, so no station waits on a tag that is being resolved in that cycle.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register has blank status (tag 0) and value zero, so every lookup returns ready with value 0 and tag 0.
- R2: A lookup of a register with blank status returns ready=1, tag=0 and the register's stored value.
- R3: A lookup of a register with a non-zero status that the result bus does not match in that cycle returns ready=0 and the status tag.
- R4: With issueValid high, the next clock edge writes issueTag into the destination register's status, replacing any earlier pending tag. With issueValid low, no status changes because of the rename port.
- R5: When bcastValid is high and a register's status equals a non-zero bcastTag, the clock edge stores bcastData in that register and clears its status to blank.
- R6: A broadcast whose tag differs from a register's status leaves that register unchanged, including the case where the register was renamed after the broadcasting producer.
- R7: A broadcast with bcastValid low, or with bcastTag equal to 0, changes no register.
- R8: When a looked-up register's status matches a valid non-zero broadcast in the same cycle, the lookup returns ready=1, tag=0 and bcastData.
- R9: When a rename and a matching broadcast hit the same register in one cycle, the register ends up holding the new tag and is not cleared.
- R10: A lookup returns the state from before any rename made in the same cycle, so an instruction whose source equals its destination sees the earlier producer or value.
- R11: The two lookup ports work independently, and they return identical results when given the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Qualifies the destination rename in this cycle |
| dstIdx | input | 4 | Destination register index |
| issueTag | input | 4 | Tag of the newly allocated station (non-zero) |
| srcAIdx | input | 4 | Source register index, port A |
| srcBIdx | input | 4 | Source register index, port B |
| bcastValid | input | 1 | Result bus carries a result |
| bcastTag | input | 4 | Tag of the producing station |
| bcastData | input | 32 | Result value |
| srcAReady | output | 1 | Port A returns a value |
| srcAValue | output | 32 | Port A value (meaningful when ready) |
| srcATag | output | 4 | Port A pending producer tag (0 when ready) |
| srcBReady | output | 1 | Port B returns a value |
| srcBValue | output | 32 | Port B value (meaningful when ready) |
| srcBTag | output | 4 | Port B pending producer tag (0 when ready) |

## Verification
The assertions assume that issueTag is never zero while issueValid is high. They also assume that a lookup index that stays the same from one cycle to the next still refers to the same register. Blank status is encoded as tag zero, so a zero issue tag would look like an immediate completion. The stimulus therefore draws issue tags only from the non-zero range, in both the directed and the pseudo-random phases. Broadcast tags can be zero, to exercise the ignored case. Tags come from a small set, so renames, overtaking producers and same-cycle collisions on one register happen often.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int NUM_RD = 2;

  typedef struct packed {
    logic renameEn;
    logic acceptEn;
  } regStrobeT;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             issueValid,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic             bcastValid,
  input  logic [TAG_W-1:0] bcastTag,
  input  logic [TAG_W-1:0] statusVec [NUM_REGS],
  input  logic [TAG_W-1:0] rdStatus  [NUM_RD],
  output regStrobeT        regStb    [NUM_REGS],
  output logic             rdBypass  [NUM_RD]
);
  logic busLive;
  assign busLive = bcastValid && (bcastTag != '0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      regStb[i].renameEn = issueValid && (dstIdx == IDX_W'(i));
      regStb[i].acceptEn = busLive && (statusVec[i] == bcastTag);
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdBypass[p] = busLive && (rdStatus[p] == bcastTag);
  end
endmodule

// File: rtl/rename_read_port.sv
module rename_read_port #(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [TAG_W-1:0]  statusVec [NUM_REGS],
  input  logic [DATA_W-1:0] valueVec  [NUM_REGS],
  input  logic [IDX_W-1:0]  idx,
  input  logic              bypass,
  input  logic [DATA_W-1:0] bcastData,
  output logic [TAG_W-1:0]  rawStatus,
  output logic              ready,
  output logic [DATA_W-1:0] value,
  output logic [TAG_W-1:0]  tag
);
  always_comb begin
    rawStatus = statusVec[idx];
    ready     = (rawStatus == '0) || bypass;
    value     = bypass ? bcastData : valueVec[idx];
    tag       = ready ? '0 : rawStatus;
  end
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [DATA_W-1:0] bcastData,
  input  regStrobeT         regStb   [NUM_REGS],
  input  logic              rdBypass [NUM_RD],
  input  logic [IDX_W-1:0]  rdIdx    [NUM_RD],
  output logic [TAG_W-1:0]  statusVec [NUM_REGS],
  output logic [TAG_W-1:0]  rdStatus [NUM_RD],
  output logic              rdReady  [NUM_RD],
  output logic [DATA_W-1:0] rdValue  [NUM_RD],
  output logic [TAG_W-1:0]  rdTag    [NUM_RD]
);
  logic [DATA_W-1:0] valueVec [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusVec[i] <= '0;
        valueVec[i]  <= '0;
      end else begin
        if (regStb[i].renameEn)      statusVec[i] <= issueTag;
        else if (regStb[i].acceptEn) statusVec[i] <= '0;
        if (regStb[i].acceptEn)      valueVec[i]  <= bcastData;
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rename_read_port #(
      .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_port (
      .statusVec(statusVec),
      .valueVec (valueVec),
      .idx      (rdIdx[p]),
      .bypass   (rdBypass[p]),
      .bcastData(bcastData),
      .rawStatus(rdStatus[p]),
      .ready    (rdReady[p]),
      .value    (rdValue[p]),
      .tag      (rdTag[p])
    );
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rename_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  output logic              srcAReady,
  output logic [DATA_W-1:0] srcAValue,
  output logic [TAG_W-1:0]  srcATag,
  output logic              srcBReady,
  output logic [DATA_W-1:0] srcBValue,
  output logic [TAG_W-1:0]  srcBTag
);
  regStrobeT         regStb    [NUM_REGS];
  logic [TAG_W-1:0]  statusVec [NUM_REGS];
  logic              rdBypass  [NUM_RD];
  logic [IDX_W-1:0]  rdIdx     [NUM_RD];
  logic [TAG_W-1:0]  rdStatus  [NUM_RD];
  logic              rdReady   [NUM_RD];
  logic [DATA_W-1:0] rdValue   [NUM_RD];
  logic [TAG_W-1:0]  rdTag     [NUM_RD];

  assign rdIdx[0] = srcAIdx;
  assign rdIdx[1] = srcBIdx;

  rename_ctrl #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_ctrl (
    .issueValid(issueValid),
    .dstIdx    (dstIdx),
    .bcastValid(bcastValid),
    .bcastTag  (bcastTag),
    .statusVec (statusVec),
    .rdStatus  (rdStatus),
    .regStb    (regStb),
    .rdBypass  (rdBypass)
  );

  rename_datapath #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .issueTag (issueTag),
    .bcastData(bcastData),
    .regStb   (regStb),
    .rdBypass (rdBypass),
    .rdIdx    (rdIdx),
    .statusVec(statusVec),
    .rdStatus (rdStatus),
    .rdReady  (rdReady),
    .rdValue  (rdValue),
    .rdTag    (rdTag)
  );

  assign srcAReady = rdReady[0];
  assign srcAValue = rdValue[0];
  assign srcATag   = rdTag[0];
  assign srcBReady = rdReady[1];
  assign srcBValue = rdValue[1];
  assign srcBTag   = rdTag[1];
endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [IDX_W-1:0]  dstIdx,
  input logic [TAG_W-1:0]  issueTag,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic [IDX_W-1:0]  srcBIdx,
  input logic              bcastValid,
  input logic [TAG_W-1:0]  bcastTag,
  input logic [DATA_W-1:0] bcastData,
  input logic              srcAReady,
  input logic [DATA_W-1:0] srcAValue,
  input logic [TAG_W-1:0]  srcATag,
  input logic              srcBReady,
  input logic [DATA_W-1:0] srcBValue,
  input logic [TAG_W-1:0]  srcBTag
);
  // R2/R3: ready and a pending tag never appear together
  assert_ready_tag_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcAReady == (srcATag == '0)) && (srcBReady == (srcBTag == '0)));

  // R8: no port hands out the tag being resolved on the bus this cycle
  assert_no_resolved_tag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bcastValid && bcastTag != '0) |-> (srcATag != bcastTag && srcBTag != bcastTag));

  // R11: both ports agree on a shared index
  assert_ports_agree_R11: assert property (@(posedge clk) disable iff (!rstN)
    (srcAIdx == srcBIdx) |->
      (srcAReady == srcBReady && srcATag == srcBTag && (!srcAReady || srcAValue == srcBValue)));

  // R4: a rename is visible on the following cycle unless its own tag is broadcast then
  assert_rename_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(issueValid) && srcAIdx == $past(dstIdx) &&
     !(bcastValid && bcastTag == $past(issueTag)))
    |-> (!srcAReady && srcATag == $past(issueTag)));

  // R5: a ready register that was not renamed stays ready with the same value
  assert_ready_persists_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(srcAReady && !(issueValid && dstIdx == srcAIdx)) && srcAIdx == $past(srcAIdx))
    |-> (srcAReady && srcAValue == $past(srcAValue)));

  // R6: a pending tag survives non-matching broadcasts
  assert_pending_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!srcAReady && !(issueValid && dstIdx == srcAIdx)) && srcAIdx == $past(srcAIdx))
    |-> (srcAReady ? (bcastValid && bcastTag == $past(srcATag) && srcAValue == bcastData)
                   : (srcATag == $past(srcATag))));
endmodule

bind rename_status_table rename_status_table_chk #(
  .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .dstIdx(dstIdx),
  .issueTag(issueTag), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
  .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
  .srcAReady(srcAReady), .srcAValue(srcAValue), .srcATag(srcATag),
  .srcBReady(srcBReady), .srcBValue(srcBValue), .srcBTag(srcBTag)
);

// File: tb/sim_rename_status_table.sv
module sim_rename_status_table;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [3:0]  dstIdx;
  logic [3:0]  issueTag;
  logic [3:0]  srcAIdx;
  logic [3:0]  srcBIdx;
  logic        bcastValid;
  logic [3:0]  bcastTag;
  logic [31:0] bcastData;
  logic        srcAReady, srcBReady;
  logic [31:0] srcAValue, srcBValue;
  logic [3:0]  srcATag, srcBTag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0]  mStat [16];
  logic [31:0] mVal  [16];

  always #5 clk = ~clk;

  rename_status_table u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .dstIdx(dstIdx),
    .issueTag(issueTag), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
    .srcAReady(srcAReady), .srcAValue(srcAValue), .srcATag(srcATag),
    .srcBReady(srcBReady), .srcBValue(srcBValue), .srcBTag(srcBTag)
  );

  task automatic idle();
    issueValid = 1'b0; dstIdx = '0; issueTag = 4'd1;
    bcastValid = 1'b0; bcastTag = '0; bcastData = '0;
  endtask

  // Expected lookup computed from the requirements (R2, R3, R8)
  task automatic checkPorts(input string req);
    #1;
    for (int p = 0; p < 2; p++) begin
      int idx = (p == 0) ? int'(srcAIdx) : int'(srcBIdx);
      logic eRdy; logic [3:0] eTag; logic [31:0] eVal; string lab;
      logic aRdy; logic [3:0] aTag; logic [31:0] aVal;
      if (mStat[idx] == 4'd0) begin
        eRdy = 1'b1; eTag = 4'd0; eVal = mVal[idx]; lab = "R2";
      end else if (bcastValid && bcastTag == mStat[idx]) begin
        eRdy = 1'b1; eTag = 4'd0; eVal = bcastData; lab = "R8";
      end else begin
        eRdy = 1'b0; eTag = mStat[idx]; eVal = '0; lab = "R3";
      end
      if (req != "") lab = req;
      aRdy = (p == 0) ? srcAReady : srcBReady;
      aTag = (p == 0) ? srcATag : srcBTag;
      aVal = (p == 0) ? srcAValue : srcBValue;
      checks++;
      if (aRdy !== eRdy || aTag !== eTag || (eRdy && aVal !== eVal)) begin
        fails++;
        $display("FAIL %s port%0d reg %0d: actual rdy=%0b tag=%0d val=%h expected rdy=%0b tag=%0d val=%h",
                 lab, p, idx, aRdy, aTag, aVal, eRdy, eTag, eVal);
      end
    end
  endtask

  // Model update per R4, R5, R6, R7, R9, then one clock
  task automatic tick();
    for (int i = 0; i < 16; i++) begin
      bit hit = bcastValid && bcastTag != 4'd0 && mStat[i] == bcastTag;
      if (hit) mVal[i] = bcastData;
      if (issueValid && int'(dstIdx) == i) mStat[i] = issueTag;
      else if (hit) mStat[i] = 4'd0;
    end
    @(posedge clk); #1;
  endtask

  task automatic look(input int a, input int b, input string req);
    srcAIdx = a[3:0]; srcBIdx = b[3:0];
    checkPorts(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    idle(); srcAIdx = '0; srcBIdx = '0; rstN = 1'b0;
    for (int i = 0; i < 16; i++) begin mStat[i] = '0; mVal[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state on every register, different indices per port
    for (int i = 0; i < 16; i++) look(i, 15 - i, "R1");

    // Load every register: rename (R4), bypass (R8), accept (R5)
    for (int r = 0; r < 16; r++) begin
      issueValid = 1'b1; dstIdx = r[3:0]; issueTag = 4'((r % 15) + 1);
      tick(); idle();
      look(r, r, "R4");
      bcastValid = 1'b1; bcastTag = 4'((r % 15) + 1); bcastData = 32'hC0DE_0000 + r * 17;
      look(r, (r + 1) % 16, "R8");
      tick(); idle();
      look(r, r, "R5");
    end

    // R6: older producer overtaken by a younger rename of reg 3
    issueValid = 1'b1; dstIdx = 4'd3; issueTag = 4'd5; tick();
    issueTag = 4'd9; tick(); idle();
    bcastValid = 1'b1; bcastTag = 4'd5; bcastData = 32'hDEAD_0005;
    look(3, 3, "R6");
    tick(); idle();
    look(3, 3, "R6");
    bcastValid = 1'b1; bcastTag = 4'd9; bcastData = 32'h0000_0909;
    tick(); idle();
    look(3, 3, "R5");

    // R7: broadcast with zero tag, and a matching tag without valid
    bcastValid = 1'b1; bcastTag = 4'd0; bcastData = 32'hBAD0_0000;
    look(5, 6, "R7");
    tick(); idle();
    look(5, 6, "R7");
    issueValid = 1'b1; dstIdx = 4'd6; issueTag = 4'd7; tick(); idle();
    bcastValid = 1'b0; bcastTag = 4'd7; bcastData = 32'hBAD0_0007;
    look(6, 6, "R7");
    tick(); idle();
    look(6, 6, "R7");
    bcastValid = 1'b1; bcastTag = 4'd7; bcastData = 32'h0000_0606; tick(); idle();

    // R9 and R10: rename and matching broadcast on reg 7 in one cycle
    issueValid = 1'b1; dstIdx = 4'd7; issueTag = 4'd2; tick();
    issueTag = 4'd11; bcastValid = 1'b1; bcastTag = 4'd2; bcastData = 32'h0000_7777;
    look(7, 7, "R10");
    tick(); idle();
    look(7, 7, "R9");
    bcastValid = 1'b1; bcastTag = 4'd11; bcastData = 32'h0000_0B0B; tick(); idle();

    // R10: source equal to destination on a blank register
    issueValid = 1'b1; dstIdx = 4'd8; issueTag = 4'd4;
    look(8, 2, "R10");
    tick(); idle();
    look(8, 2, "R4");

    // R11: identical index on both ports across all registers
    for (int i = 0; i < 16; i++) look(i, i, "R11");

    // Pseudo-random sweep with small tag set
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      issueValid = seed[16];
      dstIdx     = seed[17] ? {2'b00, seed[19:18]} : seed[23:20];
      issueTag   = 4'(1 + (seed[25:24] % 3));
      srcAIdx    = seed[26] ? {2'b00, seed[28:27]} : seed[11:8];
      srcBIdx    = seed[29] ? srcAIdx : seed[15:12];
      bcastValid = seed[30];
      bcastTag   = {2'b00, seed[7:6]};
      bcastData  = {seed[31:16], seed[15:0] ^ 16'h5A5A};
      checkPorts("");
      tick();
    end

    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule